// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block lets one analog-to-digital converter serve several inputs. It drives the select lines of an analog multiplexer and the start strobe of the converter. Each returned result leaves the block as a sample tagged with the index of the channel it came from. A sample tick from the system opens a conversion slot. When the chosen channel differs from the one currently selected, the block first moves the multiplexer and then waits out a programmable settling time, so that charge left over from the previous input does not leak into the new reading.

Three visiting orders are available. Round-robin visits each enabled channel once per scan, lowest index first. Priority order places one high-priority channel after every low-priority channel, with the high-priority channels taken in rotation. Burst order takes a fixed number of consecutive samples from each channel before it moves on. The configuration is captured when a scan begins and stays in force until that scan has finished.

Top module: `adc_scan_seq`

## Requirements
- R1: During and just after reset, `mux_sel` is 0, `adc_convert` is low and `smp_valid` is low.
- R2: With `cfg_mode` 0 (round-robin), one scan samples every channel whose `cfg_en` bit is 1, once each, in ascending index order. Scans repeat back to back.
- R3: With `cfg_mode` 1 (priority), channels with both their `cfg_en` and `cfg_hi` bits set are high-priority and the other enabled channels are low-priority. A scan visits the low channels in ascending order and follows each one with the next high channel, rotating through the high channels in ascending order from the lowest. If either group is empty, the scan is round-robin over the other group.
- R4: With `cfg_mode` 2 (burst), each enabled channel is sampled `cfg_burst` times in a row, in ascending channel order.
- R5: A slot opens in a cycle where the block is idle and `tick` is 1. If the target channel differs from `mux_sel` and the settle value is not zero, `mux_sel` changes in the next cycle and `adc_convert` is asserted exactly settle-value cycles after that. Otherwise `adc_convert` is asserted in the cycle right after the slot opens. `mux_sel` changes at no other time.
- R6: `adc_convert` is a one-cycle pulse, and no new pulse comes until `adc_done` has been sampled high for the previous one. A `tick` that arrives while a slot is in progress is dropped.
- R7: The cycle after `adc_done` is sampled high in a slot, `smp_valid` is high for exactly one cycle, with `smp_chan` equal to the converted channel and `smp_data` equal to `adc_data` from the done cycle.
- R8: While no scan is in progress and `cfg_en` is all zeros, ticks are ignored: no conversion starts and `mux_sel` stays put.
- R9: Mode, masks, settle value and burst length are sampled when a scan's first slot opens. Changes made during a scan take effect only at the next scan.
- R10: `cfg_mode` 3 behaves as round-robin, and a `cfg_burst` of 0 in burst mode behaves as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample-slot request |
| cfg_mode | input | 2 | Scan order: 0 round-robin, 1 priority, 2 burst, 3 round-robin |
| cfg_en | input | NCH | Channel enable mask |
| cfg_hi | input | NCH | High-priority mask (priority mode) |
| cfg_settle | input | SETTLE_W | Settling wait in cycles after a mux change |
| cfg_burst | input | BURST_W | Samples per channel in burst mode |
| adc_done | input | 1 | Converter finished the current conversion |
| adc_data | input | DW | Converter result, valid with adc_done |
| mux_sel | output | log2(NCH) | Analog multiplexer select |
| adc_convert | output | 1 | One-cycle conversion start strobe |
| smp_valid | output | 1 | Tagged sample valid for one cycle |
| smp_chan | output | log2(NCH) | Channel index of the sample |
| smp_data | output | DW | Sample value |

## Verification
Round-robin runs with a sparse mask and a continuous tick separate the ordering logic from the tick-drop rule, because most ticks land while a slot is busy. A priority run with one high channel among three low channels shows whether the high channel is inserted after every low channel or only once per scan. A burst run over two adjacent channels shows whether the settling wait occurs only when the channel changes. A single-channel run, an all-zero mask and a configuration change partway through a scan show the no-resettle case, the idle rule and the rule that a new configuration waits for the next scan.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
   typedef enum logic [1:0] {
      MODE_RR    = 2'd0,
      MODE_PRI   = 2'd1,
      MODE_BURST = 2'd2,
      MODE_RR_B  = 2'd3
   } scan_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETTLE = 2'd1,
      ST_CONV   = 2'd2,
      ST_WAIT   = 2'd3
   } scan_state_e;
endpackage

// File: rtl/scan_order.sv
module scan_order import adc_scan_pkg::*; #(
   parameter int NCH      = 4,
   parameter int SETTLE_W = 6,
   parameter int BURST_W  = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          cfg_mode,
   input  logic [NCH-1:0]      cfg_en,
   input  logic [NCH-1:0]      cfg_hi,
   input  logic [SETTLE_W-1:0] cfg_settle,
   input  logic [BURST_W-1:0]  cfg_burst,
   input  logic                slot_go,
   input  logic                adv,
   output logic [$clog2(NCH)-1:0] tgt_ch,
   output logic                have_work,
   output logic                at_start,
   output logic [SETTLE_W-1:0] settle_eff
);
   localparam int CHW = $clog2(NCH);

   // lowest set bit of a mask
   function automatic logic [CHW-1:0] first_set(input logic [NCH-1:0] m);
      first_set = '0;
      for (int i = NCH - 1; i >= 0; i--)
         if (m[i]) first_set = CHW'(i);
   endfunction

   // lowest set bit strictly above cur, with a found flag in the top bit
   function automatic logic [CHW:0] next_above(input logic [NCH-1:0] m,
                                                input logic [CHW-1:0] cur);
      next_above = '0;
      for (int i = NCH - 1; i >= 0; i--)
         if (m[i] && (i > int'(cur))) next_above = {1'b1, CHW'(i)};
   endfunction

   // channels that form the main walk of a scan
   function automatic logic [NCH-1:0] main_mask(input logic [1:0] md,
                                                input logic [NCH-1:0] en,
                                                input logic [NCH-1:0] hi);
      logic [NCH-1:0] lo;
      lo = en & ~hi;
      if (md == MODE_PRI) main_mask = (|lo) ? lo : (en & hi);
      else                main_mask = en;
   endfunction

   logic [1:0]          s_mode;
   logic [NCH-1:0]      s_en, s_hi;
   logic [SETTLE_W-1:0] s_settle;
   logic [BURST_W-1:0]  s_burst;
   logic [CHW-1:0]      m_idx, h_idx;
   logic                take_hi;
   logic [BURST_W-1:0]  bcnt;

   logic [NCH-1:0]      live_main, snap_main, live_hm, snap_hm;
   logic                interleave;
   logic [BURST_W:0]    burst_len;
   logic [CHW:0]        nxt_main, nxt_hi;

   assign live_main  = main_mask(cfg_mode, cfg_en, cfg_hi);
   assign snap_main  = main_mask(s_mode, s_en, s_hi);
   assign live_hm    = cfg_en & cfg_hi;
   assign snap_hm    = s_en & s_hi;
   assign interleave = (s_mode == MODE_PRI) && (|(s_en & ~s_hi)) && (|snap_hm);
   assign burst_len  = (s_burst == '0) ? (BURST_W+1)'(1) : {1'b0, s_burst};
   assign nxt_main   = next_above(snap_main, m_idx);
   assign nxt_hi     = next_above(snap_hm, h_idx);

   assign tgt_ch     = at_start ? first_set(live_main) : (take_hi ? h_idx : m_idx);
   assign have_work  = at_start ? (|cfg_en) : 1'b1;
   assign settle_eff = at_start ? cfg_settle : s_settle;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         at_start <= 1'b1;
         s_mode   <= '0;
         s_en     <= '0;
         s_hi     <= '0;
         s_settle <= '0;
         s_burst  <= '0;
         m_idx    <= '0;
         h_idx    <= '0;
         take_hi  <= 1'b0;
         bcnt     <= '0;
      end else if (slot_go && at_start) begin
         at_start <= 1'b0;
         s_mode   <= cfg_mode;
         s_en     <= cfg_en;
         s_hi     <= cfg_hi;
         s_settle <= cfg_settle;
         s_burst  <= cfg_burst;
         m_idx    <= first_set(live_main);
         h_idx    <= first_set(live_hm);
         take_hi  <= 1'b0;
         bcnt     <= '0;
      end else if (adv) begin
         if (interleave && !take_hi) begin
            take_hi <= 1'b1;
         end else if (s_mode == MODE_BURST &&
                      ({1'b0, bcnt} + (BURST_W+1)'(1)) < burst_len) begin
            bcnt <= bcnt + 1'b1;
         end else begin
            bcnt    <= '0;
            take_hi <= 1'b0;
            if (interleave)
               h_idx <= nxt_hi[CHW] ? nxt_hi[CHW-1:0] : first_set(snap_hm);
            if (nxt_main[CHW]) m_idx <= nxt_main[CHW-1:0];
            else               at_start <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         run,
   output logic         expire
);
   logic [W-1:0] cnt;

   assign expire = (cnt == W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)                 cnt <= '0;
      else if (load)              cnt <= load_val;
      else if (run && cnt != '0)  cnt <= cnt - 1'b1;
   end
endmodule

// File: rtl/sample_out.sv
module sample_out #(
   parameter int CHW = 2,
   parameter int DW  = 12
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cap,
   input  logic [CHW-1:0] cap_ch,
   input  logic [DW-1:0]  cap_data,
   output logic           smp_valid,
   output logic [CHW-1:0] smp_chan,
   output logic [DW-1:0]  smp_data
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         smp_valid <= 1'b0;
         smp_chan  <= '0;
         smp_data  <= '0;
      end else begin
         smp_valid <= cap;
         if (cap) begin
            smp_chan <= cap_ch;
            smp_data <= cap_data;
         end
      end
   end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq import adc_scan_pkg::*; #(
   parameter int NCH      = 4,
   parameter int DW       = 12,
   parameter int SETTLE_W = 6,
   parameter int BURST_W  = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   tick,
   input  logic [1:0]             cfg_mode,
   input  logic [NCH-1:0]         cfg_en,
   input  logic [NCH-1:0]         cfg_hi,
   input  logic [SETTLE_W-1:0]    cfg_settle,
   input  logic [BURST_W-1:0]     cfg_burst,
   input  logic                   adc_done,
   input  logic [DW-1:0]          adc_data,
   output logic [$clog2(NCH)-1:0] mux_sel,
   output logic                   adc_convert,
   output logic                   smp_valid,
   output logic [$clog2(NCH)-1:0] smp_chan,
   output logic [DW-1:0]          smp_data
);
   localparam int CHW = $clog2(NCH);

   if (NCH < 2) begin : g_bad_nch
      $error("adc_scan_seq: NCH must be at least 2");
   end
   if (SETTLE_W < 1 || BURST_W < 1) begin : g_bad_w
      $error("adc_scan_seq: SETTLE_W and BURST_W must be positive");
   end
   if (DW < 1) begin : g_bad_dw
      $error("adc_scan_seq: DW must be positive");
   end

   scan_state_e         st_q;
   logic [CHW-1:0]      mux_q, tgt_ch;
   logic                have_work, at_start, st_idle, slot_go, adv, expire, need_wait;
   logic [SETTLE_W-1:0] settle_eff;

   assign st_idle     = (st_q == ST_IDLE);
   assign slot_go     = st_idle && tick && have_work;
   assign adv         = (st_q == ST_WAIT) && adc_done;
   assign need_wait   = (tgt_ch != mux_q) && (settle_eff != '0);
   assign mux_sel     = mux_q;
   assign adc_convert = (st_q == ST_CONV);

   scan_order #(.NCH(NCH), .SETTLE_W(SETTLE_W), .BURST_W(BURST_W)) u_order (
      .clk(clk), .rst_n(rst_n),
      .cfg_mode(cfg_mode), .cfg_en(cfg_en), .cfg_hi(cfg_hi),
      .cfg_settle(cfg_settle), .cfg_burst(cfg_burst),
      .slot_go(slot_go), .adv(adv),
      .tgt_ch(tgt_ch), .have_work(have_work), .at_start(at_start),
      .settle_eff(settle_eff)
   );

   settle_timer #(.W(SETTLE_W)) u_settle (
      .clk(clk), .rst_n(rst_n),
      .load(slot_go), .load_val(settle_eff),
      .run(st_q == ST_SETTLE), .expire(expire)
   );

   sample_out #(.CHW(CHW), .DW(DW)) u_out (
      .clk(clk), .rst_n(rst_n),
      .cap(adv), .cap_ch(mux_q), .cap_data(adc_data),
      .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_data(smp_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         mux_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (slot_go) begin
               mux_q <= tgt_ch;
               st_q  <= need_wait ? ST_SETTLE : ST_CONV;
            end
            ST_SETTLE: if (expire) st_q <= ST_CONV;
            ST_CONV:   st_q <= ST_WAIT;
            ST_WAIT:   if (adc_done) st_q <= ST_IDLE;
            default:   st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
   parameter int NCH      = 4,
   parameter int SETTLE_W = 6
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   tick,
   input logic                   adc_convert,
   input logic                   adc_done,
   input logic [$clog2(NCH)-1:0] mux_sel,
   input logic                   smp_valid,
   input logic [NCH-1:0]         cfg_en,
   input logic                   at_start,
   input logic [SETTLE_W-1:0]    settle_eff,
   input logic                   st_idle
);
   localparam int CHW = $clog2(NCH);
   localparam int AW  = SETTLE_W + 1;

   logic           outstanding, dirty, moved;
   logic [CHW-1:0] prev_mux;
   logic [AW-1:0]  age_q, age;

   assign moved = (mux_sel != prev_mux);
   assign age   = moved ? '0 : age_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         outstanding <= 1'b0;
         dirty       <= 1'b0;
         prev_mux    <= '0;
         age_q       <= '0;
      end else begin
         prev_mux <= mux_sel;
         if (adc_convert)   outstanding <= 1'b1;
         else if (adc_done) outstanding <= 1'b0;
         if (adc_convert) dirty <= 1'b0;
         else if (moved)  dirty <= 1'b1;
         if (moved)              age_q <= AW'(1);
         else if (age_q != '1)   age_q <= age_q + 1'b1;
      end
   end

   // R6: only one conversion in flight
   p_one_outstanding_r6: assert property (@(posedge clk) disable iff (!rst_n)
      adc_convert |-> !outstanding);
   p_convert_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      adc_convert |=> !adc_convert);
   // R5: settling time honoured after a mux move
   p_settle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (adc_convert && (dirty || moved)) |-> (age >= {1'b0, settle_eff}));
   p_mux_move_r5: assert property (@(posedge clk) disable iff (!rst_n)
      moved |-> $past(st_idle && tick));
   // R7: sample strobe follows done and lasts one cycle
   p_valid_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |-> $past(adc_done));
   p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |=> !smp_valid);
   // R8: empty mask with no scan running keeps the converter quiet
   p_empty_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_idle && at_start && cfg_en == '0) |=> !adc_convert);
endmodule

bind adc_scan_seq adc_scan_chk #(.NCH(NCH), .SETTLE_W(SETTLE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .adc_convert(adc_convert),
   .adc_done(adc_done), .mux_sel(mux_sel), .smp_valid(smp_valid),
   .cfg_en(cfg_en), .at_start(at_start), .settle_eff(settle_eff),
   .st_idle(st_idle)
);

// File: tb/sim_adc_scan_seq.sv
`timescale 1ns/1ps
module sim_adc_scan_seq;
   localparam int NCH = 4, DW = 12, SW = 6, BW = 4;
   localparam int CHW = $clog2(NCH);

   logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, adc_done = 1'b0;
   logic [1:0] cfg_mode = '0;
   logic [NCH-1:0] cfg_en = '0, cfg_hi = '0;
   logic [SW-1:0] cfg_settle = '0;
   logic [BW-1:0] cfg_burst = '0;
   logic [DW-1:0] adc_data = '0;
   logic [CHW-1:0] mux_sel, smp_chan;
   logic adc_convert, smp_valid;
   logic [DW-1:0] smp_data;

   always #10 clk = ~clk;

   adc_scan_seq #(.NCH(NCH), .DW(DW), .SETTLE_W(SW), .BURST_W(BW)) u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_mode(cfg_mode),
      .cfg_en(cfg_en), .cfg_hi(cfg_hi), .cfg_settle(cfg_settle),
      .cfg_burst(cfg_burst), .adc_done(adc_done), .adc_data(adc_data),
      .mux_sel(mux_sel), .adc_convert(adc_convert), .smp_valid(smp_valid),
      .smp_chan(smp_chan), .smp_data(smp_data));

   int checks = 0, failures = 0;
   string cur_req = "R1";
   bit finished = 0, cmp_on = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // ---------------- stimulus helpers ----------------
   int tick_per = 1, tcnt = 0, adc_lat = 2, adc_cnt = 0, data_seed = 5;
   int converts = 0;
   int per_ch[NCH];

   always @(negedge clk) begin
      tcnt++;
      tick = rst_n && ((tick_per == 1) || (tcnt % tick_per == 0));
      adc_done = 1'b0;
      if (adc_convert) begin
         adc_cnt = adc_lat;
         converts++;
      end else if (adc_cnt > 0) begin
         adc_cnt--;
         if (adc_cnt == 0) begin
            adc_done = 1'b1;
            data_seed = (data_seed * 13 + 7) % 4096;
            adc_data = DW'(data_seed);
         end
      end
      if (smp_valid) per_ch[smp_chan]++;
   end

   // ---------------- reference model ----------------
   int seq[$];
   int m_st = 0, m_cnt = 0, m_mux = 0, m_settle = 0, m_chan = 0, m_data = 0;
   bit m_valid = 0;

   task automatic build_scan();
      int lo[$], hi[$], hp, reps;
      seq.delete();
      if (cfg_mode == 2'd1) begin
         for (int c = 0; c < NCH; c++)
            if (cfg_en[c]) begin
               if (cfg_hi[c]) hi.push_back(c); else lo.push_back(c);
            end
         if (lo.size() == 0) foreach (hi[i]) seq.push_back(hi[i]);
         else if (hi.size() == 0) foreach (lo[i]) seq.push_back(lo[i]);
         else begin
            hp = 0;
            foreach (lo[i]) begin
               seq.push_back(lo[i]);
               seq.push_back(hi[hp]);
               hp = (hp + 1) % hi.size();
            end
         end
      end else begin
         reps = (cfg_mode == 2'd2) ? ((cfg_burst == 0) ? 1 : int'(cfg_burst)) : 1;
         for (int c = 0; c < NCH; c++)
            if (cfg_en[c]) for (int k = 0; k < reps; k++) seq.push_back(c);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_mux = 0; m_valid = 0; m_chan = 0; m_data = 0;
         seq.delete();
      end else begin
         m_valid = 0;
         case (m_st)
            0: if (tick) begin
               if (seq.size() == 0 && cfg_en != '0) begin
                  m_settle = int'(cfg_settle);
                  build_scan();
               end
               if (seq.size() != 0) begin
                  if (seq[0] != m_mux && m_settle != 0) begin
                     m_st = 1; m_cnt = m_settle;
                  end else m_st = 2;
                  m_mux = seq[0];
               end
            end
            1: if (m_cnt == 1) m_st = 2; else m_cnt--;
            2: m_st = 3;
            default: if (adc_done) begin
               m_valid = 1; m_chan = m_mux; m_data = int'(adc_data);
               void'(seq.pop_front());
               m_st = 0;
            end
         endcase
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (cmp_on) begin
         bit ok;
         ok = (int'(mux_sel) == m_mux) && (adc_convert == (m_st == 2)) &&
              (smp_valid == m_valid) &&
              (!m_valid || (int'(smp_chan) == m_chan && int'(smp_data) == m_data));
         check(ok, cur_req, "cycle mux/convert/valid/chan",
               {int'(mux_sel), 4'(adc_convert), 4'(smp_valid), 8'(smp_chan)},
               {m_mux, 4'(m_st == 2), 4'(m_valid), 8'(m_chan)});
      end
   end

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_scan_end();
      int guard = 0;
      @(negedge clk);
      while ((seq.size() != 0 || m_st != 0) && guard < 2000) begin
         @(negedge clk); guard++;
      end
   endtask

   task automatic clear_counts();
      converts = 0;
      for (int c = 0; c < NCH; c++) per_ch[c] = 0;
   endtask

   initial begin
      for (int c = 0; c < NCH; c++) per_ch[c] = 0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(mux_sel == '0, "R1", "mux_sel in reset", int'(mux_sel), 0);
      check(!adc_convert, "R1", "convert in reset", int'(adc_convert), 0);
      check(!smp_valid, "R1", "valid in reset", int'(smp_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(mux_sel == '0 && !adc_convert && !smp_valid, "R1", "state after reset",
            {int'(mux_sel), int'(adc_convert), int'(smp_valid)}, 0);
      cmp_on = 1;

      // R2 R5 R6 R7: round-robin, sparse mask, continuous tick
      cur_req = "R2/R5/R6/R7";
      cfg_mode = 2'd0; cfg_en = 4'b1011; cfg_settle = 6'd3; tick_per = 1; adc_lat = 2;
      clear_counts();
      run(200);
      check(per_ch[2] == 0, "R2", "samples of disabled ch2", per_ch[2], 0);
      check(per_ch[0] > 4 && per_ch[0] - per_ch[3] <= 1 && per_ch[3] <= per_ch[0],
            "R2", "equal round-robin rate ch0 vs ch3", per_ch[3], per_ch[0]);
      wait_scan_end();

      // R3: priority, one high channel among three low ones
      cur_req = "R3";
      cfg_mode = 2'd1; cfg_hi = 4'b0010; cfg_en = 4'b1111; cfg_settle = 6'd2; adc_lat = 3;
      clear_counts();
      run(300);
      check(per_ch[1] > 2 * per_ch[0], "R3", "high ch1 visited more than low ch0",
            per_ch[1], 2 * per_ch[0] + 1);
      wait_scan_end();

      // R3: two low, two high, sparse tick
      cfg_hi = 4'b1100; tick_per = 4; adc_lat = 1; cfg_settle = 6'd1;
      run(250);
      wait_scan_end();

      // R4: burst, adjacent channels
      cur_req = "R4/R5";
      cfg_mode = 2'd2; cfg_en = 4'b0110; cfg_burst = 4'd3; cfg_settle = 6'd4;
      tick_per = 1; adc_lat = 2;
      clear_counts();
      run(250);
      check(per_ch[1] >= 3 && per_ch[0] == 0, "R4", "burst samples on ch1", per_ch[1], 3);
      wait_scan_end();

      // R10: burst length 0 acts as 1, mode 3 acts as round-robin
      cur_req = "R10";
      cfg_burst = 4'd0; cfg_en = 4'b1001;
      run(120);
      wait_scan_end();
      cfg_mode = 2'd3; cfg_en = 4'b0111; cfg_settle = 6'd0;
      run(120);
      wait_scan_end();

      // R5: single channel, no re-settle between its samples
      cur_req = "R5";
      cfg_mode = 2'd0; cfg_en = 4'b0100; cfg_settle = 6'd6;
      run(150);
      wait_scan_end();

      // R8: empty mask keeps the converter idle
      cur_req = "R8";
      cfg_en = '0;
      clear_counts();
      run(100);
      check(converts == 0, "R8", "conversions with empty mask", converts, 0);
      check(int'(mux_sel) == 2, "R8", "mux held with empty mask", int'(mux_sel), 2);

      // R9: change configuration partway through a scan
      cur_req = "R9";
      cfg_mode = 2'd0; cfg_en = 4'b1111; cfg_settle = 6'd5; tick_per = 7;
      run(30);
      cfg_en = 4'b0001; cfg_mode = 2'd1; cfg_settle = 6'd1;
      clear_counts();
      run(200);
      check(per_ch[3] >= 1, "R9", "old scan finished on ch3 after change", per_ch[3], 1);
      wait_scan_end();

      cmp_on = 0;
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog all-R actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule